// File: doc/BRIEF.md
# Victim Replication Slice Controller

This block controls the slice of a distributed shared second-level cache that sits beside one core. The slice holds two kinds of lines. Home lines are those whose address maps to this slice. Replicas are copies of lines whose home is another slice. Each line carries a flag that marks it as a replica or a home line.

When the core's first-level cache drops a line, the controller offers the line to the local slice. A replica is taken only into a free way. A home line may also displace a replica. When the first-level cache misses, the local slice is searched first, and a hit is answered on the next cycle. On a local miss, one forward pulse is sent toward the home slice, and the block waits for the home's answer. Invalidations from the coherence side remove matching replicas at once, because this core is still listed as a sharer.

Top module: `vr_slice_ctrl`

## Requirements
- R1: After reset every entry is invalid, `resp_valid` and `fwd_valid` are low, `req_ready` is high, and the first request to any address misses.
- R2: Address fields (defaults): the set is `addr[1:0]` and the home slice is `addr[3:2]`. This slice is slice 0. A dropped line whose home is not this slice is stored as a replica when its set has an invalid way. A later request to that address gets `resp_valid` with the stored data one cycle after acceptance, with no forward.
- R3: A replica never displaces a valid line. A remote victim that arrives at a full set is discarded, and the resident lines stay readable.
- R4: A dropped line whose home is this slice fills an invalid way first. If the set has none, it overwrites a replica. It never overwrites another home line, so it is discarded when the set holds only home lines.
- R5: A dropped line whose address is already resident has its data updated in place. It takes no extra way and keeps its replica flag.
- R6: On a local miss, `fwd_valid` pulses for exactly one cycle, one cycle after acceptance, carrying the request address on `fwd_addr`. `req_ready` stays low until `home_valid` arrives. The home data appears on `resp_data` with `resp_valid` one cycle after `home_valid`.
- R7: An invalidation that matches a valid replica clears it in the same cycle, so a following request misses. An invalidation that matches a home line, or matches nothing, has no effect.
- R8: When an eviction and an invalidation carry the same remote address in the same cycle, the line is not retained.
- R9: A `home_valid` that arrives while no miss is outstanding produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evict_valid | input | 1 | L1 victim offered this cycle |
| evict_addr | input | 12 | Victim line address |
| evict_data | input | 16 | Victim line data |
| req_valid | input | 1 | L1 miss request |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | 12 | Requested line address |
| resp_valid | output | 1 | Response to the L1, one-cycle pulse |
| resp_data | output | 16 | Response data |
| fwd_valid | output | 1 | Request forwarded to the home slice, one-cycle pulse |
| fwd_addr | output | 12 | Forwarded address |
| home_valid | input | 1 | Home slice answer |
| home_data | input | 16 | Data from the home slice |
| inv_valid | input | 1 | Invalidation arriving |
| inv_addr | input | 12 | Line address to invalidate |

## Verification
The assertions assume the following about the inputs:
- `req_valid` is raised only while `req_ready` is high.
- `home_valid` arrives only after a forward, except in the R9 test, where it is deliberately stray.
- An eviction never sends a second copy of a line whose copy in the set differs.

The stimulus drives one operation per cycle on the negative edge. It raises a request only when the controller is idle. It answers each forward exactly once. The single deliberate overlap is the same-address eviction and invalidation of R8.

// File: rtl/vr_pkg.sv
package vr_pkg;
  typedef enum logic {
    MS_IDLE = 1'b0,
    MS_WAIT = 1'b1
  } miss_st_e;
endpackage

// File: rtl/vr_way_match.sv
module vr_way_match #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 10
) (
  input  logic [WAYS-1:0]       valid,
  input  logic [WAYS*TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]      key,
  output logic                  hit,
  output logic [WAYS-1:0]       hit_vec
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hit_vec[w] = valid[w] && (tags[w*TAG_W +: TAG_W] == key);
  end
  assign hit = |hit_vec;
endmodule

// File: rtl/vr_way_pick.sv
module vr_way_pick #(
  parameter int WAYS = 2
) (
  input  logic [WAYS-1:0] valid,
  input  logic [WAYS-1:0] repl,
  input  logic            allow_repl,
  output logic            found,
  output logic [WAYS-1:0] pick
);
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !valid[w]) begin
        pick[w] = 1'b1;
        found   = 1'b1;
      end
    end
    if (!found && allow_repl) begin
      for (int w = 0; w < WAYS; w++) begin
        if (!found && repl[w]) begin
          pick[w] = 1'b1;
          found   = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vr_miss_ctrl.sv
module vr_miss_ctrl
  import vr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_hit,
  input  logic [DATA_W-1:0] hit_data,
  input  logic              home_valid,
  input  logic [DATA_W-1:0] home_data,
  output logic              req_ready,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_data,
  output logic              fwd_valid,
  output logic [ADDR_W-1:0] fwd_addr
);
  miss_st_e          st_q, st_d;
  logic              rv_d, fv_d;
  logic [DATA_W-1:0] rd_d;
  logic [ADDR_W-1:0] fa_d;

  assign req_ready = (st_q == MS_IDLE);

  always_comb begin
    st_d = st_q;
    rv_d = 1'b0;
    rd_d = resp_data;
    fv_d = 1'b0;
    fa_d = fwd_addr;
    case (st_q)
      MS_IDLE: if (req_valid) begin
        if (req_hit) begin
          rv_d = 1'b1;
          rd_d = hit_data;
        end else begin
          fv_d = 1'b1;
          fa_d = req_addr;
          st_d = MS_WAIT;
        end
      end
      MS_WAIT: if (home_valid) begin
        rv_d = 1'b1;
        rd_d = home_data;
        st_d = MS_IDLE;
      end
      default: st_d = MS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= MS_IDLE;
      resp_valid <= 1'b0;
      fwd_valid  <= 1'b0;
    end else begin
      st_q       <= st_d;
      resp_valid <= rv_d;
      fwd_valid  <= fv_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rv_d) resp_data <= rd_d;
    if (fv_d) fwd_addr  <= fa_d;
  end

  a_r6_fwd_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |=> !fwd_valid);
  a_r6_busy_while_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> !req_ready);
  a_r6_resp_after_home: assert property (@(posedge clk) disable iff (!rst_n)
    (home_valid && !req_ready) |=> (resp_valid && resp_data == $past(home_data)));
  a_r9_stray_home_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (home_valid && req_ready && !req_valid) |=> !resp_valid);
endmodule

// File: rtl/vr_slice_ctrl.sv
module vr_slice_ctrl #(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 16,
  parameter int SETS     = 4,
  parameter int WAYS     = 2,
  parameter int SLICE_W  = 2,
  parameter int MY_SLICE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evict_valid,
  input  logic [ADDR_W-1:0] evict_addr,
  input  logic [DATA_W-1:0] evict_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_data,
  output logic              fwd_valid,
  output logic [ADDR_W-1:0] fwd_addr,
  input  logic              home_valid,
  input  logic [DATA_W-1:0] home_data,
  input  logic              inv_valid,
  input  logic [ADDR_W-1:0] inv_addr
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam logic [SLICE_W-1:0] MY_ID = SLICE_W'(MY_SLICE);

  logic [SETS-1:0][WAYS-1:0] valid_q, repl_q;
  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [DATA_W-1:0] data_q [SETS][WAYS];

  logic [IDX_W-1:0] ev_set, rq_set, iv_set;
  logic [TAG_W-1:0] ev_tag, rq_tag, iv_tag;
  logic [WAYS*TAG_W-1:0] ev_tags, rq_tags, iv_tags;
  logic [WAYS-1:0] ev_hit_vec, rq_hit_vec, iv_hit_vec, pick_vec, ev_we, inv_clr;
  logic ev_hit, rq_hit, iv_hit, pick_found, ev_remote, ev_install, same_inv;
  logic [DATA_W-1:0] hit_data;

  assign ev_set = evict_addr[IDX_W-1:0];
  assign rq_set = req_addr[IDX_W-1:0];
  assign iv_set = inv_addr[IDX_W-1:0];
  assign ev_tag = evict_addr[ADDR_W-1:IDX_W];
  assign rq_tag = req_addr[ADDR_W-1:IDX_W];
  assign iv_tag = inv_addr[ADDR_W-1:IDX_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_flat
    assign ev_tags[w*TAG_W +: TAG_W] = tag_q[ev_set][w];
    assign rq_tags[w*TAG_W +: TAG_W] = tag_q[rq_set][w];
    assign iv_tags[w*TAG_W +: TAG_W] = tag_q[iv_set][w];
  end

  vr_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) i_ev_match (
    .valid(valid_q[ev_set]), .tags(ev_tags), .key(ev_tag), .hit(ev_hit), .hit_vec(ev_hit_vec));
  vr_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) i_rq_match (
    .valid(valid_q[rq_set]), .tags(rq_tags), .key(rq_tag), .hit(rq_hit), .hit_vec(rq_hit_vec));
  vr_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) i_iv_match (
    .valid(valid_q[iv_set]), .tags(iv_tags), .key(iv_tag), .hit(iv_hit), .hit_vec(iv_hit_vec));

  assign ev_remote = (evict_addr[IDX_W +: SLICE_W] != MY_ID);

  vr_way_pick #(.WAYS(WAYS)) i_pick (
    .valid(valid_q[ev_set]), .repl(repl_q[ev_set]), .allow_repl(!ev_remote),
    .found(pick_found), .pick(pick_vec));

  always_comb begin
    same_inv   = inv_valid && (inv_addr == evict_addr);
    ev_install = evict_valid && !ev_hit;
    ev_we      = '0;
    if (evict_valid) begin
      if (ev_hit)                                  ev_we = ev_hit_vec;
      else if (pick_found && !(ev_remote && same_inv)) ev_we = pick_vec;
    end
    inv_clr  = (inv_valid && iv_hit) ? (iv_hit_vec & repl_q[iv_set]) : '0;
    hit_data = '0;
    for (int w = 0; w < WAYS; w++)
      if (rq_hit_vec[w]) hit_data = hit_data | data_q[rq_set][w];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      repl_q  <= '0;
    end else begin
      for (int w = 0; w < WAYS; w++) begin
        if (ev_we[w]) begin
          valid_q[ev_set][w] <= 1'b1;
          if (ev_install) repl_q[ev_set][w] <= ev_remote;
        end
        if (inv_clr[w]) valid_q[iv_set][w] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int w = 0; w < WAYS; w++) begin
      if (ev_we[w]) begin
        tag_q[ev_set][w]  <= ev_tag;
        data_q[ev_set][w] <= evict_data;
      end
    end
  end

  vr_miss_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_miss (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_hit(rq_hit), .hit_data(hit_data), .home_valid(home_valid), .home_data(home_data),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_data(resp_data),
    .fwd_valid(fwd_valid), .fwd_addr(fwd_addr));

  a_r3_replica_takes_free_way: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_install && ev_remote && |ev_we) |-> ((ev_we & valid_q[ev_set]) == '0));
  a_r4_home_spares_home: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_install && !ev_remote && |ev_we) |-> ((ev_we & valid_q[ev_set] & ~repl_q[ev_set]) == '0));
  a_r7_inv_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (|inv_clr) |=> ((valid_q[$past(iv_set)] & $past(inv_clr)) == '0));
  a_r5_single_copy: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $onehot0(rq_hit_vec));
endmodule

// File: tb/test_vr_slice_ctrl.sv
module test_vr_slice_ctrl;
  logic clk, rst_n;
  logic evict_valid, req_valid, req_ready, resp_valid, fwd_valid, home_valid, inv_valid;
  logic [11:0] evict_addr, req_addr, fwd_addr, inv_addr;
  logic [15:0] evict_data, resp_data, home_data;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  vr_slice_ctrl i_vr_slice_ctrl (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // op: 0 evict, 1 request, 2 invalidate; kind: 1 hit, 2 miss (data = home answer)
  localparam int NV = 22;
  localparam logic [47:0] VEC [NV] = '{
    {2'd0, 12'h015, 16'h1111, 2'd0, 16'h0000},  // R2 replica into free way
    {2'd1, 12'h015, 16'h0000, 2'd1, 16'h1111},  // R2 hit
    {2'd0, 12'h025, 16'h2222, 2'd0, 16'h0000},  // R2 second replica, set full
    {2'd0, 12'h035, 16'h3333, 2'd0, 16'h0000},  // R3 dropped
    {2'd1, 12'h035, 16'h3C3C, 2'd2, 16'h0000},  // R3 miss
    {2'd1, 12'h025, 16'h0000, 2'd1, 16'h2222},  // R3 resident kept
    {2'd0, 12'h015, 16'h1A1A, 2'd0, 16'h0000},  // R5 in-place update
    {2'd1, 12'h015, 16'h0000, 2'd1, 16'h1A1A},  // R5
    {2'd2, 12'h015, 16'h0000, 2'd0, 16'h0000},  // R7 invalidate replica
    {2'd1, 12'h015, 16'h4444, 2'd2, 16'h0000},  // R7 now misses
    {2'd0, 12'h035, 16'h3333, 2'd0, 16'h0000},  // R5 freed way reused
    {2'd1, 12'h035, 16'h0000, 2'd1, 16'h3333},  // R5
    {2'd0, 12'h102, 16'h5555, 2'd0, 16'h0000},  // R4 home line
    {2'd0, 12'h016, 16'h6666, 2'd0, 16'h0000},  // R2 replica in home set
    {2'd0, 12'h202, 16'h7777, 2'd0, 16'h0000},  // R4 overwrites replica
    {2'd1, 12'h016, 16'h6A6A, 2'd2, 16'h0000},  // R4 replica gone
    {2'd1, 12'h102, 16'h0000, 2'd1, 16'h5555},  // R4
    {2'd1, 12'h202, 16'h0000, 2'd1, 16'h7777},  // R4
    {2'd0, 12'h302, 16'h8888, 2'd0, 16'h0000},  // R4 all home: dropped
    {2'd1, 12'h302, 16'h8A8A, 2'd2, 16'h0000},  // R4
    {2'd2, 12'h102, 16'h0000, 2'd0, 16'h0000},  // R7 home line untouched
    {2'd1, 12'h102, 16'h0000, 2'd1, 16'h5555}   // R7
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic do_evict(input logic [11:0] a, input logic [15:0] d);
    evict_valid = 1; evict_addr = a; evict_data = d;
    @(negedge clk); evict_valid = 0;
  endtask

  task automatic do_inv(input logic [11:0] a);
    inv_valid = 1; inv_addr = a;
    @(negedge clk); inv_valid = 0;
  endtask

  task automatic do_hit(input string rq, input logic [11:0] a, input logic [15:0] e);
    req_valid = 1; req_addr = a;
    @(negedge clk); req_valid = 0;
    chk({rq, " hit resp_valid"}, resp_valid, 1);
    chk({rq, " hit data"}, resp_data, e);
    chk({rq, " hit no forward"}, fwd_valid, 0);
  endtask

  task automatic do_miss(input string rq, input logic [11:0] a, input logic [15:0] hd);
    req_valid = 1; req_addr = a;
    @(negedge clk); req_valid = 0;
    chk({rq, " fwd_valid"}, fwd_valid, 1);
    chk({rq, " fwd_addr"}, fwd_addr, a);
    chk({rq, " busy"}, req_ready, 0);
    chk({rq, " no early resp"}, resp_valid, 0);
    @(negedge clk);
    chk({rq, " R6 fwd pulse ends"}, fwd_valid, 0);
    home_valid = 1; home_data = hd;
    @(negedge clk); home_valid = 0;
    chk({rq, " R6 resp_valid"}, resp_valid, 1);
    chk({rq, " R6 resp_data"}, resp_data, hd);
    chk({rq, " R6 ready again"}, req_ready, 1);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 0; evict_valid = 0; req_valid = 0; home_valid = 0; inv_valid = 0;
    evict_addr = '0; evict_data = '0; req_addr = '0; home_data = '0; inv_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 resp_valid", resp_valid, 0);
    chk("R1 fwd_valid", fwd_valid, 0);
    chk("R1 req_ready", req_ready, 1);
    do_miss("R1 empty", 12'h015, 16'hABCD);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op, kind;
      logic [11:0] a;
      logic [15:0] d, e;
      {op, a, d, kind, e} = VEC[i];
      case (op)
        2'd0: do_evict(a, d);
        2'd2: do_inv(a);
        default: if (kind == 2'd1) do_hit($sformatf("vec%0d", i), a, e);
                 else do_miss($sformatf("vec%0d", i), a, d);
      endcase
    end

    // R7 invalidation matching nothing leaves residents intact
    do_inv(12'hFF5);
    do_hit("R7 unmatched inv", 12'h035, 16'h3333);

    // R8 same-cycle eviction and invalidation of a remote line
    evict_valid = 1; evict_addr = 12'h017; evict_data = 16'h9999;
    inv_valid = 1; inv_addr = 12'h017;
    @(negedge clk); evict_valid = 0; inv_valid = 0;
    do_miss("R8", 12'h017, 16'h9A9A);

    // R9 stray home answer
    home_valid = 1; home_data = 16'hDEAD;
    @(negedge clk); home_valid = 0;
    chk("R9 no resp", resp_valid, 0);
    @(negedge clk);
    chk("R9 still idle", req_ready, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule